// File: doc/BRIEF.md
# Delayed Bus Parity Generator and Checker

This block protects a multiplexed address/data bus with even parity. The lower lane covers 32 address/data bits and 4 command/byte-enable bits. An optional upper lane, selected by a parameter, covers another 32 data bits and 4 byte-enable bits. When the local device drives the bus, the block forms the parity bit for that cycle and presents it one clock later, together with an output enable for the parity pad. A parity bit therefore always trails the word it protects by exactly one cycle.

When the device receives, the block holds its own parity of the sampled word. It compares that parity with the bit that arrives on the parity input in the following cycle. A mismatch is reported one cycle after that, which is two cycles after the word.

Phase qualifiers come from the surrounding bus control logic: address phase, transfer completed, local device driving, target selected, and special-cycle. Errors found on completed data phases go to the data-error pulse. Errors found on address phases, and on special-cycle data, go to the system-error pulse. A sticky flag records any reported error until software clears it with a one-cycle clear pulse. The block only reports errors: it does not retry and it does not correct.

Top module: `busp_unit`

## Requirements
- R1: While the local device drives the bus in cycle N, `par_o` in cycle N+1 equals the XOR of `ad_i[31:0]` and `cbe_i[3:0]` as sampled in cycle N. The parity is even, so the ones count across those 36 bits plus `par_o` is even.
- R2: `par_oe_o` is high in cycle N+1 exactly when `drive_en_i` was high in cycle N.
- R3: With the wide option, `par_hi_o` in cycle N+1 equals the XOR of `ad_i[63:32]` and `cbe_i[7:4]` from cycle N.
- R4: A received data cycle N qualifies when `xfer_done_i`=1, `tgt_sel_i`=1, `drive_en_i`=0, `addr_ph_i`=0 and `special_i`=0. If `par_i` in cycle N+1 differs from the parity of cycle N, `perr_o` is high for exactly cycle N+2. A matching parity produces no pulse.
- R5: No `perr_o` follows a cycle without a completed transfer, a cycle without target selection, or a cycle the local device drove, whatever parity arrives afterwards.
- R6: A parity mismatch on a received address phase (`addr_ph_i`=1, `drive_en_i`=0) raises `serr_o` two cycles later and never `perr_o`.
- R7: A parity mismatch on a received completed special-cycle data phase (`special_i`=1, `xfer_done_i`=1) raises `serr_o` two cycles later and not `perr_o`.
- R8: Upper-lane mismatches (`par_hi_i` against the upper lane) count on an address phase only when `wide_req_i`=1, and on a data phase only when both `wide_req_i` and `wide_ack_i` are 1.
- R9: Byte lanes disabled by their enable bit are still included in the parity. Changing a data byte whose `cbe_i` bit is 0 changes `par_o`.
- R10: `err_sticky_o` goes high together with any `perr_o` or `serr_o` pulse and stays high. A high `err_clr_i` in cycle N clears it in cycle N+1, unless an error is reported in cycle N+1; in that case the error wins.
- R11: While `rst_n` is low at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 64 | Sampled address/data lines (upper 32 used with the wide option) |
| cbe_i | input | 8 | Sampled command/byte-enable line values |
| drive_en_i | input | 1 | Local device drives address/data this cycle |
| addr_ph_i | input | 1 | This cycle is an address phase |
| xfer_done_i | input | 1 | A data transfer completes this cycle |
| tgt_sel_i | input | 1 | A target has claimed the transaction |
| special_i | input | 1 | Current transaction is a broadcast special cycle |
| wide_req_i | input | 1 | Wide transfer requested |
| wide_ack_i | input | 1 | Wide transfer acknowledged |
| par_i | input | 1 | Incoming lower-lane parity |
| par_hi_i | input | 1 | Incoming upper-lane parity |
| err_clr_i | input | 1 | Write-one pulse that clears the sticky flag |
| par_o | output | 1 | Generated lower-lane parity |
| par_hi_o | output | 1 | Generated upper-lane parity |
| par_oe_o | output | 1 | Parity pad output enable |
| perr_o | output | 1 | Data-phase parity error pulse |
| serr_o | output | 1 | Address or special-cycle parity error pulse |
| err_sticky_o | output | 1 | Sticky record of any reported error |

## Verification
The bench targets the two-cycle spacing between word and report:
- A design that compared the parity bit against the word from the same cycle would flag clean traffic.
- A design that reported one cycle early would miss the comparison window.

It sends mismatches down each route. An address-phase error routed to `perr_o`, or a special-cycle error treated as ordinary data, would show up on the wrong pin. Upper-lane mismatches are injected with the request and acknowledge pairs that must mask them, to catch a checker that ignores the acknowledge. A clear pulse that lands in the same cycle as a new error shows whether the error wins.

// File: rtl/busp_pkg.sv
// Shared constants and the per-cycle check qualifier type for the bus parity unit.
// Assumes the bus is built from identical 32-bit lanes with one enable bit per byte.
package busp_pkg;
    localparam int LANE_AD_W = 32;
    localparam int LANE_BE_W = LANE_AD_W / 8;

    // Qualifiers captured with a received word, consumed one cycle later.
    typedef struct packed {
        logic chk_data;  // completed data phase to a selected target
        logic chk_sys;   // address phase or special-cycle data
        logic hi_en;     // upper lane participates
    } busp_qual_t;
endpackage

// File: rtl/busp_lane_tree.sv
// Even-parity reduction for one bus lane: all address/data bits plus all
// enable-line values. Disabled byte lanes are included unconditionally.
// Purely combinational; assumes AD_W is a multiple of 8.
module busp_lane_tree #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] be_i,
    output logic            par_o
);
    localparam int NBYTE = AD_W / 8;

    logic [NBYTE-1:0] byte_par;

    // One XOR leaf per byte keeps the tree balanced across lanes.
    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        assign byte_par[g] = ^ad_i[8*g +: 8];
    end

    // Fold the byte leaves with the enable lines.
    assign par_o = (^byte_par) ^ (^be_i);
endmodule

// File: rtl/busp_drive.sv
// Output stage: registers the lane parities and the pad enable so that they
// trail the driven word by one clock. Assumes drive_en_i is qualified upstream.
module busp_drive #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en_i,
    input  logic [LANES-1:0] calc_i,
    output logic [LANES-1:0] par_o,
    output logic             oe_o
);
    // Delay parity and enable by one cycle behind the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_o <= '0;
            oe_o  <= 1'b0;
        end else begin
            par_o <= calc_i;
            oe_o  <= drive_en_i;
        end
    end

    assert_oe_follows_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_i |=> oe_o);
    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en_i |=> !oe_o);
endmodule

// File: rtl/busp_check.sv
// Receive checker: stage one captures the local parity and phase qualifiers of
// a received word, stage two compares them with the parity bit arriving one
// cycle later and issues a registered error pulse on the proper route.
// Assumes the qualifiers are mutually consistent per bus cycle.
module busp_check import busp_pkg::*; #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] calc_i,
    input  logic [LANES-1:0] par_in_i,
    input  logic             drive_en_i,
    input  logic             addr_ph_i,
    input  logic             xfer_done_i,
    input  logic             tgt_sel_i,
    input  logic             special_i,
    input  logic             wide_req_i,
    input  logic             wide_ack_i,
    output logic             perr_o,
    output logic             serr_o
);
    busp_qual_t       qual_d, qual_q;
    logic [LANES-1:0] calc_q;
    logic             mism_lo, mism_hi, mism;

    // Decide which route, if any, a word in this cycle will be checked on.
    always_comb begin
        qual_d.chk_data = xfer_done_i & tgt_sel_i & ~drive_en_i & ~addr_ph_i & ~special_i;
        qual_d.chk_sys  = ~drive_en_i & (addr_ph_i | (xfer_done_i & special_i));
        qual_d.hi_en    = addr_ph_i ? wide_req_i : (wide_req_i & wide_ack_i);
    end

    // Stage one: hold the word's parity and qualifiers until its parity bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q <= '0;
            calc_q <= '0;
        end else begin
            qual_q <= qual_d;
            calc_q <= calc_i;
        end
    end

    assign mism_lo = par_in_i[0] ^ calc_q[0];

    if (LANES > 1) begin : g_hi
        assign mism_hi = (par_in_i[1] ^ calc_q[1]) & qual_q.hi_en;
    end else begin : g_no_hi
        assign mism_hi = 1'b0;
    end

    assign mism = mism_lo | mism_hi;

    // Stage two: register the report so it trails the parity bit by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_o <= 1'b0;
            serr_o <= 1'b0;
        end else begin
            perr_o <= qual_q.chk_data & mism;
            serr_o <= qual_q.chk_sys & mism;
        end
    end

    assert_perr_needs_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> ($past(xfer_done_i, 2) && $past(tgt_sel_i, 2) && !$past(drive_en_i, 2)));
    assert_addr_not_perr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> !$past(addr_ph_i, 2));
    assert_serr_needs_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> ($past(addr_ph_i, 2) || $past(special_i, 2)));
endmodule

// File: rtl/busp_unit.sv
// Top of the delayed bus parity unit. Builds one parity tree per lane, feeds
// the output stage and the receive checker, and keeps the sticky error flag.
// Assumes all inputs are synchronous to clk; WIDE_EN adds the upper lane.
module busp_unit import busp_pkg::*; #(
    parameter bit WIDE_EN  = 1'b1,
    parameter int LANES    = WIDE_EN ? 2 : 1,
    parameter int BUS_W    = LANE_AD_W * LANES,
    parameter int BUS_BE_W = LANE_BE_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_W-1:0]    ad_i,
    input  logic [BUS_BE_W-1:0] cbe_i,
    input  logic                drive_en_i,
    input  logic                addr_ph_i,
    input  logic                xfer_done_i,
    input  logic                tgt_sel_i,
    input  logic                special_i,
    input  logic                wide_req_i,
    input  logic                wide_ack_i,
    input  logic                par_i,
    input  logic                par_hi_i,
    input  logic                err_clr_i,
    output logic                par_o,
    output logic                par_hi_o,
    output logic                par_oe_o,
    output logic                perr_o,
    output logic                serr_o,
    output logic                err_sticky_o
);
    logic [LANES-1:0] calc;
    logic [LANES-1:0] par_in;
    logic [LANES-1:0] par_drv;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        busp_lane_tree #(.AD_W(LANE_AD_W), .BE_W(LANE_BE_W)) u_tree (
            .ad_i  (ad_i[l*LANE_AD_W +: LANE_AD_W]),
            .be_i  (cbe_i[l*LANE_BE_W +: LANE_BE_W]),
            .par_o (calc[l])
        );
    end

    if (WIDE_EN) begin : g_wide
        assign par_in   = {par_hi_i, par_i};
        assign par_hi_o = par_drv[LANES-1];
    end else begin : g_narrow
        assign par_in   = par_i;
        assign par_hi_o = 1'b0;
    end

    assign par_o = par_drv[0];

    busp_drive #(.LANES(LANES)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en_i (drive_en_i),
        .calc_i     (calc),
        .par_o      (par_drv),
        .oe_o       (par_oe_o)
    );

    busp_check #(.LANES(LANES)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .calc_i      (calc),
        .par_in_i    (par_in),
        .drive_en_i  (drive_en_i),
        .addr_ph_i   (addr_ph_i),
        .xfer_done_i (xfer_done_i),
        .tgt_sel_i   (tgt_sel_i),
        .special_i   (special_i),
        .wide_req_i  (wide_req_i),
        .wide_ack_i  (wide_ack_i),
        .perr_o      (perr_o),
        .serr_o      (serr_o)
    );

    // The checker registers its pulses, so rebuild their next values here to
    // set the sticky flag in the same cycle as the pulse.
    logic err_next;
    assign err_next = (u_check.qual_q.chk_data | u_check.qual_q.chk_sys) & u_check.mism;

    // Sticky flag: new errors win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky_o <= 1'b0;
        end else begin
            err_sticky_o <= (err_sticky_o & ~err_clr_i) | err_next;
        end
    end

    assert_sticky_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_o || serr_o) |-> err_sticky_o);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> (err_sticky_o == (perr_o || serr_o)));
endmodule

// File: tb/busp_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for busp_unit: a behavioural model predicts every output after every
// clock edge and compares it with the design.
module busp_unit_tb_top;
    typedef struct {
        logic [63:0] ad;
        logic [7:0]  be;
        bit drv, adr, xfr, sel, spc, req, ack, p, ph, clr, rst;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n;
    logic [63:0] ad;
    logic [7:0]  cbe;
    logic drive_en, addr_ph, xfer_done, tgt_sel, special, wreq, wack, par_in, par_hi_in, clr;
    logic par_o, par_hi_o, par_oe_o, perr_o, serr_o, sticky_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R11";

    stim_t h1;
    bit    h1_valid = 0;
    bit    m_sticky = 0;

    always #2.5 clk = ~clk;

    busp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe),
        .drive_en_i(drive_en), .addr_ph_i(addr_ph), .xfer_done_i(xfer_done),
        .tgt_sel_i(tgt_sel), .special_i(special), .wide_req_i(wreq), .wide_ack_i(wack),
        .par_i(par_in), .par_hi_i(par_hi_in), .err_clr_i(clr),
        .par_o(par_o), .par_hi_o(par_hi_o), .par_oe_o(par_oe_o),
        .perr_o(perr_o), .serr_o(serr_o), .err_sticky_o(sticky_o)
    );

    function automatic bit plo(stim_t s);
        return ^{s.ad[31:0], s.be[3:0]};
    endfunction

    function automatic bit phi(stim_t s);
        return ^{s.ad[63:32], s.be[7:4]};
    endfunction

    function automatic stim_t idle();
        stim_t s;
        s.ad = '0; s.be = '0;
        s.drv = 0; s.adr = 0; s.xfr = 0; s.sel = 0; s.spc = 0;
        s.req = 0; s.ack = 0; s.p = 0; s.ph = 0; s.clr = 0; s.rst = 0;
        return s;
    endfunction

    task automatic chk(string t, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", t, nm, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, then compare every output with the model.
    task automatic step(stim_t s);
        bit e_par, e_ph, e_oe, e_perr, e_serr, mm, hien, dchk, schk;
        @(negedge clk);
        rst_n = !s.rst; ad = s.ad; cbe = s.be; drive_en = s.drv; addr_ph = s.adr;
        xfer_done = s.xfr; tgt_sel = s.sel; special = s.spc; wreq = s.req; wack = s.ack;
        par_in = s.p; par_hi_in = s.ph; clr = s.clr;
        @(posedge clk);
        #1;
        if (s.rst) begin
            e_par = 0; e_ph = 0; e_oe = 0; e_perr = 0; e_serr = 0;
            m_sticky = 0; h1_valid = 0;
        end else begin
            e_par = plo(s); e_ph = phi(s); e_oe = s.drv;
            e_perr = 0; e_serr = 0;
            if (h1_valid) begin
                hien = h1.adr ? h1.req : (h1.req && h1.ack);
                mm   = (s.p != plo(h1)) || (hien && (s.ph != phi(h1)));
                dchk = h1.xfr && h1.sel && !h1.drv && !h1.adr && !h1.spc;
                schk = !h1.drv && (h1.adr || (h1.xfr && h1.spc));
                e_perr = dchk && mm;
                e_serr = schk && mm;
            end
            m_sticky = (m_sticky && !s.clr) || e_perr || e_serr;
            h1 = s; h1_valid = 1;
        end
        chk((tag == "R9") ? "R9" : (s.rst ? "R11" : "R1"), "par_o", par_o, e_par);
        chk(s.rst ? "R11" : "R3", "par_hi_o", par_hi_o, e_ph);
        chk(s.rst ? "R11" : "R2", "par_oe_o", par_oe_o, e_oe);
        chk(tag, "perr_o", perr_o, e_perr);
        chk(tag, "serr_o", serr_o, e_serr);
        chk(s.rst ? "R11" : ((tag == "R10") ? "R10" : tag), "err_sticky_o", sticky_o, m_sticky);
    endtask

    // Receive one word, then its parity (optionally corrupted), then settle.
    task automatic rx(stim_t w, bit flip_lo, bit flip_hi);
        stim_t n;
        step(w);
        n = idle();
        n.p  = plo(w) ^ flip_lo;
        n.ph = phi(w) ^ flip_hi;
        step(n);
        step(idle());
        step(idle());
    endtask

    function automatic stim_t rnd_word();
        stim_t s = idle();
        s.ad = {$urandom(), $urandom()};
        s.be = 8'($urandom());
        return s;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        stim_t s;
        // R11: reset state
        s = rnd_word(); s.rst = 1; s.drv = 1; s.xfr = 1; s.sel = 1;
        tag = "R11";
        step(s); step(s);
        // R1/R2/R3: drive random words
        tag = "R1";
        for (int i = 0; i < 20; i++) begin
            s = rnd_word(); s.drv = (i % 3) != 0;
            step(s);
        end
        // R9: disabled lanes still in parity
        tag = "R9";
        s = idle(); s.drv = 1; s.be = 8'h00; s.ad = 64'h0000_0000_0000_0100; step(s);
        s.ad = 64'h0000_0000_0000_0000; step(s);
        s.be = 8'h0E; s.ad = 64'h0000_0000_0000_0003; step(s);
        step(idle());
        // R4: good and bad data parity
        tag = "R4";
        for (int i = 0; i < 6; i++) begin
            s = rnd_word(); s.xfr = 1; s.sel = 1;
            rx(s, i[0], 1'b0);
        end
        // R5: unqualified cycles never report data errors
        tag = "R5";
        s = rnd_word(); s.xfr = 0; s.sel = 1; rx(s, 1, 1);
        s = rnd_word(); s.xfr = 1; s.sel = 0; rx(s, 1, 1);
        s = rnd_word(); s.xfr = 1; s.sel = 1; s.drv = 1; rx(s, 1, 1);
        // R6: address-phase errors go to the system route
        tag = "R6";
        s = rnd_word(); s.adr = 1; rx(s, 1, 0);
        s = rnd_word(); s.adr = 1; rx(s, 0, 0);
        s = rnd_word(); s.adr = 1; s.drv = 1; rx(s, 1, 0);
        // R7: special-cycle data errors go to the system route
        tag = "R7";
        s = rnd_word(); s.spc = 1; s.xfr = 1; rx(s, 1, 0);
        s = rnd_word(); s.spc = 1; s.xfr = 1; rx(s, 0, 0);
        // R8: upper-lane gating
        tag = "R8";
        s = rnd_word(); s.adr = 1; s.req = 0; rx(s, 0, 1);
        s = rnd_word(); s.adr = 1; s.req = 1; rx(s, 0, 1);
        s = rnd_word(); s.xfr = 1; s.sel = 1; s.req = 1; s.ack = 0; rx(s, 0, 1);
        s = rnd_word(); s.xfr = 1; s.sel = 1; s.req = 1; s.ack = 1; rx(s, 0, 1);
        s = rnd_word(); s.xfr = 1; s.sel = 1; s.req = 0; s.ack = 1; rx(s, 0, 1);
        // R10: clear, hold, and error-wins-over-clear
        tag = "R10";
        s = idle(); s.clr = 1; step(s);
        step(idle()); step(idle());
        s = rnd_word(); s.xfr = 1; s.sel = 1; step(s);
        s = idle(); s.p = plo(h1) ^ 1'b1; step(s);
        s = idle(); s.clr = 1; step(s);
        step(idle());
        s = idle(); s.clr = 1; step(s);
        step(idle());
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule